// File: doc/BRIEF.md
# Instruction Cache Parity Checker

This block sits beside the read port of an instruction cache and inspects each set lookup as it returns. A lookup delivers one 64-bit instruction chunk with four parity bits, plus the tag of every way in the set, each tag with one parity bit of its own. When a check fails, the block asks for every line in the accessed set to be invalidated. It then asks for the line to be fetched again from backing memory. For each lookup that fails it also gives one pulse to the cache error counter. No data is corrected.

Lookups arrive on a valid/ready stream. The checker never applies back-pressure: `lk_ready` is held high, so a lookup is taken in any cycle in which `lk_valid` is high, and a new lookup may come in every cycle. Whether parity is even or odd is set by a parameter. The invalidate and refetch requests are plain single-cycle pulses, and each one carries the set index.

Top module: `icache_par_chk`

## Requirements
- R1: After reset, `inval_req`, `refetch_req` and `err_event` are low until the first lookup that fails is taken.
- R2: On a lookup taken with `lk_hit` high, the chunk is split into four 16-bit slices. Slice i is `lk_data[16i+15:16i]` and is checked against `lk_data_par[i]`. A mismatch in any slice marks the lookup as failing.
- R3: The tag of way w is `lk_tags[w*TAG_W +: TAG_W]` and is checked against `lk_tag_par[w]` whenever `lk_way_valid[w]` is high. A mismatch in any such way marks the lookup as failing.
- R4: With `ODD_PARITY`=0, a group passes when the number of ones in the group plus its parity bit is even. With `ODD_PARITY`=1, that number must be odd.
- R5: `inval_req` is high for exactly the one cycle after a failing lookup is taken, and in that cycle `inval_set` equals that lookup's `lk_set`.
- R6: `refetch_req` is high in the cycle after `inval_req`, and `refetch_set` equals the `inval_set` of that invalidate.
- R7: Each failing lookup produces exactly one `err_event` pulse, in the same cycle as its `inval_req`.
- R8: Several inputs are ignored. Data parity has no effect when `lk_hit` is low. Tag parity has no effect on ways whose valid bit is low. Nothing at all has an effect while `lk_valid` is low.
- R9: Flipping an even number of bits inside a single parity group is not detected. The same flips spread over two groups are detected.
- R10: `lk_ready` is always high, so every cycle with `lk_valid` high takes one lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_ready | output | 1 | Lookup accepted (held high) |
| lk_set | input | SET_W | Set index of the lookup |
| lk_hit | input | 1 | Fetch hit in this set, so the data is checked |
| lk_data | input | DATA_W | Instruction chunk read from the hit way |
| lk_data_par | input | DATA_W/SLICE_W | One parity bit per slice |
| lk_way_valid | input | WAYS | Valid bit of each way |
| lk_tags | input | WAYS*TAG_W | Tags of all ways, way 0 in the low bits |
| lk_tag_par | input | WAYS | One parity bit per tag |
| inval_req | output | 1 | Pulse: invalidate every line of `inval_set` |
| inval_set | output | SET_W | Set to invalidate |
| refetch_req | output | 1 | Pulse: fetch the line again from backing memory |
| refetch_set | output | SET_W | Set being refetched |
| err_event | output | 1 | Pulse to the cache error counter |

## Verification
The assertions run on every cycle and check the timing relations between outputs. An idle or clean cycle is never followed by an invalidate. Every invalidate carries the set of the lookup before it. A refetch always follows an invalidate one cycle later with the same set, and an error event never appears without an invalidate. The bench scenarios check what parity actually decides. They cover single-bit faults in data slices and tags, faults that must be ignored on misses and invalid ways, double flips inside one slice versus across two slices, and the opposite verdicts given by an even-parity and an odd-parity instance fed the same words.

// File: rtl/icp_pkg.sv
package icp_pkg;
  // Number of ones in a group (data plus parity bit) reduced to one bit.
  // The group is bad when that bit differs from the wanted polarity.
  function automatic logic group_bad(input logic ones_odd, input logic want_odd);
    return ones_odd ^ want_odd;
  endfunction
endpackage

// File: rtl/icp_data_chk.sv
module icp_data_chk #(
  parameter int DATA_W     = 64,
  parameter int SLICE_W    = 16,
  parameter bit ODD_PARITY = 1'b0,
  localparam int NSLICE    = DATA_W / SLICE_W
) (
  input  logic              check_en,
  input  logic [DATA_W-1:0] data,
  input  logic [NSLICE-1:0] par,
  output logic              any_bad
);
  logic [NSLICE-1:0] slice_bad;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign slice_bad[s] = check_en &
      icp_pkg::group_bad(^{data[s*SLICE_W +: SLICE_W], par[s]}, ODD_PARITY);
  end

  assign any_bad = |slice_bad;
endmodule

// File: rtl/icp_tag_chk.sv
module icp_tag_chk #(
  parameter int WAYS       = 4,
  parameter int TAG_W      = 20,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic                  check_en,
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS-1:0]       par,
  output logic                  any_bad
);
  logic [WAYS-1:0] way_bad;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_bad[w] = check_en & way_valid[w] &
      icp_pkg::group_bad(^{tags[w*TAG_W +: TAG_W], par[w]}, ODD_PARITY);
  end

  assign any_bad = |way_bad;
endmodule

// File: rtl/icp_err_seq.sv
module icp_err_seq #(
  parameter int SET_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail,
  input  logic [SET_W-1:0] fail_set,
  output logic             inval_req,
  output logic [SET_W-1:0] inval_set,
  output logic             refetch_req,
  output logic [SET_W-1:0] refetch_set,
  output logic             err_event
);
  // Stage one: invalidate and count. Stage two: refetch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inval_req   <= 1'b0;
      inval_set   <= '0;
      err_event   <= 1'b0;
      refetch_req <= 1'b0;
      refetch_set <= '0;
    end else begin
      inval_req   <= fail;
      err_event   <= fail;
      refetch_req <= inval_req;
      if (fail)      inval_set   <= fail_set;
      if (inval_req) refetch_set <= inval_set;
    end
  end
endmodule

// File: rtl/icache_par_chk.sv
module icache_par_chk #(
  parameter int DATA_W     = 64,
  parameter int SLICE_W    = 16,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 20,
  parameter int SET_W      = 7,
  parameter bit ODD_PARITY = 1'b0,
  localparam int NSLICE    = DATA_W / SLICE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  output logic                  lk_ready,
  input  logic [SET_W-1:0]      lk_set,
  input  logic                  lk_hit,
  input  logic [DATA_W-1:0]     lk_data,
  input  logic [NSLICE-1:0]     lk_data_par,
  input  logic [WAYS-1:0]       lk_way_valid,
  input  logic [WAYS*TAG_W-1:0] lk_tags,
  input  logic [WAYS-1:0]       lk_tag_par,
  output logic                  inval_req,
  output logic [SET_W-1:0]      inval_set,
  output logic                  refetch_req,
  output logic [SET_W-1:0]      refetch_set,
  output logic                  err_event
);
  logic take, data_bad, tag_bad;

  assign lk_ready = 1'b1;
  assign take     = lk_valid & lk_ready;

  icp_data_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .ODD_PARITY(ODD_PARITY)) u_data (
    .check_en(take & lk_hit), .data(lk_data), .par(lk_data_par), .any_bad(data_bad)
  );

  icp_tag_chk #(.WAYS(WAYS), .TAG_W(TAG_W), .ODD_PARITY(ODD_PARITY)) u_tag (
    .check_en(take), .way_valid(lk_way_valid), .tags(lk_tags), .par(lk_tag_par),
    .any_bad(tag_bad)
  );

  icp_err_seq #(.SET_W(SET_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .fail(data_bad | tag_bad), .fail_set(lk_set),
    .inval_req(inval_req), .inval_set(inval_set), .refetch_req(refetch_req),
    .refetch_set(refetch_set), .err_event(err_event)
  );
endmodule

// File: rtl/icache_par_chk_sva.sv
module icache_par_chk_sva #(
  parameter int SET_W = 7,
  parameter int WAYS  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [SET_W-1:0] lk_set,
  input logic             lk_hit,
  input logic [WAYS-1:0]  lk_way_valid,
  input logic             inval_req,
  input logic [SET_W-1:0] inval_set,
  input logic             refetch_req,
  input logic [SET_W-1:0] refetch_set,
  input logic             err_event
);
  // R8: an idle cycle, or a miss with no valid way, never leads to an invalidate.
  a_r8_quiet_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid || (!lk_hit && lk_way_valid == '0)) |=> !inval_req);

  // R5: the invalidate carries the set of the lookup taken one cycle earlier.
  a_r5_inval_set: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (!inval_req || inval_set == $past(lk_set)));

  // R6: the refetch follows the invalidate with the same set.
  a_r6_refetch_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inval_req |=> (refetch_req && refetch_set == $past(inval_set)));

  // R6: no refetch without an invalidate before it.
  a_r6_no_lone_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    !inval_req |=> !refetch_req);

  // R7: the error event and the invalidate appear together.
  a_r7_event_with_inval: assert property (@(posedge clk) disable iff (!rst_n)
    err_event == inval_req);

  // R10: the stream is never back-pressured.
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n) lk_ready);
endmodule

bind icache_par_chk icache_par_chk_sva #(.SET_W(SET_W), .WAYS(WAYS)) i_sva (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_set(lk_set),
  .lk_hit(lk_hit), .lk_way_valid(lk_way_valid), .inval_req(inval_req),
  .inval_set(inval_set), .refetch_req(refetch_req), .refetch_set(refetch_set),
  .err_event(err_event)
);

// File: tb/test_icache_par_chk.sv
module test_icache_par_chk;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64, SLICE_W = 16, WAYS = 4, TAG_W = 20, SET_W = 7;
  localparam int NSLICE = DATA_W / SLICE_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_hit = 1'b0;
  logic [SET_W-1:0] lk_set = '0;
  logic [DATA_W-1:0] lk_data = '0;
  logic [NSLICE-1:0] lk_data_par = '0;
  logic [WAYS-1:0] lk_way_valid = '0, lk_tag_par = '0;
  logic [WAYS*TAG_W-1:0] lk_tags = '0;

  logic e_rdy, e_inv, e_ref, e_evt, o_rdy, o_inv, o_ref, o_evt;
  logic [SET_W-1:0] e_iset, e_rset, o_iset, o_rset;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_par_chk #(.ODD_PARITY(1'b0)) i_icache_par_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(e_rdy), .lk_set(lk_set),
    .lk_hit(lk_hit), .lk_data(lk_data), .lk_data_par(lk_data_par),
    .lk_way_valid(lk_way_valid), .lk_tags(lk_tags), .lk_tag_par(lk_tag_par),
    .inval_req(e_inv), .inval_set(e_iset), .refetch_req(e_ref), .refetch_set(e_rset),
    .err_event(e_evt)
  );

  icache_par_chk #(.ODD_PARITY(1'b1)) i_icache_par_chk_odd (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(o_rdy), .lk_set(lk_set),
    .lk_hit(lk_hit), .lk_data(lk_data), .lk_data_par(lk_data_par),
    .lk_way_valid(lk_way_valid), .lk_tags(lk_tags), .lk_tag_par(lk_tag_par),
    .inval_req(o_inv), .inval_set(o_iset), .refetch_req(o_ref), .refetch_set(o_rset),
    .err_event(o_evt)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NSLICE-1:0] good_dpar(input logic [DATA_W-1:0] d, input logic odd);
    logic [NSLICE-1:0] p;
    for (int s = 0; s < NSLICE; s++) p[s] = (^d[s*SLICE_W +: SLICE_W]) ^ odd;
    return p;
  endfunction

  function automatic logic [WAYS-1:0] good_tpar(input logic [WAYS*TAG_W-1:0] t, input logic odd);
    logic [WAYS-1:0] p;
    for (int w = 0; w < WAYS; w++) p[w] = (^t[w*TAG_W +: TAG_W]) ^ odd;
    return p;
  endfunction

  // Model of R2, R3, R4, R8: does this lookup fail for the given polarity?
  function automatic logic model_fail(input logic odd);
    logic f = 1'b0;
    if (lk_hit)
      for (int s = 0; s < NSLICE; s++)
        if (((^lk_data[s*SLICE_W +: SLICE_W]) ^ lk_data_par[s]) != odd) f = 1'b1;
    for (int w = 0; w < WAYS; w++)
      if (lk_way_valid[w] && (((^lk_tags[w*TAG_W +: TAG_W]) ^ lk_tag_par[w]) != odd)) f = 1'b1;
    return f;
  endfunction

  // Drive one lookup, then check invalidate, event and refetch of both instances.
  task automatic lookup(input string req, input logic valid, input logic exp_e_fixed,
                        input logic use_fixed);
    logic xe, xo;
    logic [SET_W-1:0] s;
    lk_valid = valid;
    s  = lk_set;
    xe = valid && model_fail(1'b0);
    xo = valid && model_fail(1'b1);
    if (use_fixed) chk(xe == exp_e_fixed, {req, " model"}, xe, exp_e_fixed);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(e_inv == xe, {req, " even inval"}, e_inv, xe);
    chk(e_evt == xe, {req, " R7 even event"}, e_evt, xe);
    chk(o_inv == xo, {req, " R4 odd inval"}, o_inv, xo);
    if (xe) chk(e_iset == s, {req, " R5 inval_set"}, e_iset, s);
    @(negedge clk);
    chk(e_inv == 1'b0, {req, " R5 single pulse"}, e_inv, 0);
    chk(e_evt == 1'b0, {req, " R7 single event"}, e_evt, 0);
    chk(e_ref == xe, {req, " R6 refetch"}, e_ref, xe);
    if (xe) chk(e_rset == s, {req, " R6 refetch_set"}, e_rset, s);
    chk(o_ref == xo, {req, " R6 odd refetch"}, o_ref, xo);
  endtask

  task automatic load_clean(input logic [SET_W-1:0] set, input logic hit, input logic odd);
    lk_set = set;
    lk_hit = hit;
    lk_data = 64'h1234_5678_9ABC_DEF0 ^ {57'd0, set};
    lk_data_par = good_dpar(lk_data, odd);
    lk_way_valid = '1;
    lk_tags = {20'hA5A5A, 20'h01234, 20'hFFFFF, 20'h0F0F1} ^ {73'd0, set};
    lk_tag_par = good_tpar(lk_tags, odd);
  endtask

  task automatic t_reset;
    chk(e_inv == 0 && e_ref == 0 && e_evt == 0, "R1 reset outputs", {e_inv, e_ref, e_evt}, 0);
    chk(o_inv == 0 && o_ref == 0 && o_evt == 0, "R1 reset outputs odd", {o_inv, o_ref, o_evt}, 0);
  endtask

  task automatic t_clean;
    load_clean(7'd3, 1'b1, 1'b0);
    lookup("R2 R3 clean even", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_data_slices;
    for (int s = 0; s < NSLICE; s++) begin
      load_clean(7'(10 + s), 1'b1, 1'b0);
      lk_data[s*SLICE_W + 5] = ~lk_data[s*SLICE_W + 5];
      lookup("R2 data slice flip", 1'b1, 1'b1, 1'b1);
    end
    load_clean(7'd20, 1'b1, 1'b0);
    lk_data_par[2] = ~lk_data_par[2];
    lookup("R2 data parity bit flip", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_tags;
    load_clean(7'd33, 1'b0, 1'b0);
    lk_tags[2*TAG_W + 7] = ~lk_tags[2*TAG_W + 7];
    lookup("R3 tag flip valid way", 1'b1, 1'b1, 1'b1);
    load_clean(7'd34, 1'b1, 1'b0);
    lk_way_valid[1] = 1'b0;
    lk_tag_par[1] = ~lk_tag_par[1];
    lookup("R8 tag flip invalid way", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_ignored;
    load_clean(7'd40, 1'b0, 1'b0);
    lk_data[3] = ~lk_data[3];
    lookup("R8 data bad on miss", 1'b1, 1'b0, 1'b1);
    load_clean(7'd41, 1'b1, 1'b0);
    lk_data[3] = ~lk_data[3];
    lk_tag_par[0] = ~lk_tag_par[0];
    lookup("R8 bad lookup without valid", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_double;
    load_clean(7'd50, 1'b1, 1'b0);
    lk_data[17] = ~lk_data[17];
    lk_data[30] = ~lk_data[30];
    lookup("R9 double flip one slice", 1'b1, 1'b0, 1'b1);
    load_clean(7'd51, 1'b1, 1'b0);
    lk_data[1]  = ~lk_data[1];
    lk_data[60] = ~lk_data[60];
    lookup("R9 double flip two slices", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_odd;
    load_clean(7'd60, 1'b1, 1'b1);
    lookup("R4 odd-good word", 1'b1, 1'b1, 1'b1);
    chk(e_rdy && o_rdy, "R10 ready high", {e_rdy, o_rdy}, 3);
  endtask

  task automatic t_back_to_back;
    load_clean(7'd70, 1'b1, 1'b0);
    lk_data[0] = ~lk_data[0];
    lk_valid = 1'b1;
    @(negedge clk);
    lk_set = 7'd71;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(e_inv && e_iset == 7'd71, "R5 second pulse set", e_iset, 71);
    chk(e_ref && e_rset == 7'd70, "R6 refetch of first", e_rset, 70);
    @(negedge clk);
    chk(e_ref && e_rset == 7'd71, "R6 refetch of second", e_rset, 71);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_data_slices();
    t_tags();
    t_ignored();
    t_double();
    t_odd();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule